// File: doc/BRIEF.md
# LCD Controller Register Access Sequencer

This block sits between a register-access client and a serial shift engine that talks to an LCD controller. The client asks for a 16-bit register write or read through a valid/ready handshake. The sequencer splits every access into two serial frames and hands them to the shift engine one after the other. Each frame is loaded, started and then awaited until the engine reports done.

Each frame opens with an 8-bit header. The header is a 6-bit device identifier in its upper bits, followed by a register-select bit and a direction bit. The first frame always carries the register index. The second frame carries the value for a write. For a read, the second frame is a longer frame: after its header goes out, the engine shifts in 24 bits from the panel, and the low 16 of those bits form the read result. The read result is returned with a one-cycle valid pulse.

Top module: `lcd_reg_seq`

## Requirements
- R1: After a synchronous reset, `req_ready` is 1 and `spi_load`, `spi_start` and `rsp_valid` are 0.
- R2: The first frame of every access is 24 bits long (`spi_len` = 23, i.e. bit count minus one) with `spi_tx` = {8'h00, header, index}. With the default identifier 0x1C, this header is 0x70 (select bit 1 = 0, direction bit 0 = 0).
- R3: The second frame of a write is 24 bits long (`spi_len` = 23) with `spi_tx` = {8'h00, 8'h72, value}, where header 0x72 has select bit 1 set.
- R4: The second frame of a read is 32 bits long (`spi_len` = 31) with `spi_tx` = {8'h72, 24'h000000}.
- R5: Each frame is presented with a one-cycle `spi_load` pulse, followed in the next cycle by a one-cycle `spi_start` pulse. The second frame's load appears exactly two cycles after the clock edge at which the first frame's `spi_done` is sampled.
- R6: A request is accepted at a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the cycle after acceptance until the cycle after the second frame's `spi_done` is sampled. The first load appears two cycles after the accepting edge.
- R7: For a read, `rsp_valid` pulses for one cycle in the cycle after the final `spi_done` is sampled. `rsp_rdata` equals the `spi_rx` value present at that done. A write never raises `rsp_valid`.
- R8: A `spi_done` seen while no frame is outstanding (idle, or in the load and start cycles) has no effect on frames, readiness or responses.
- R9: Index, value and direction are captured at acceptance. Later changes on the request inputs do not alter the frames of the access in progress.
- R10: Back-to-back requests are served in order. A request held valid is accepted on the first edge at which `req_ready` is back at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_index | input | 16 | LCD controller register index |
| req_wdata | input | 16 | Value to write |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| rsp_valid | output | 1 | Read result pulse |
| rsp_rdata | output | 16 | Read result |
| spi_load | output | 1 | Frame and length are valid this cycle |
| spi_tx | output | 32 | Frame to shift, MSB first, aligned to its length |
| spi_len | output | 5 | Frame length in bits minus one |
| spi_start | output | 1 | Start shifting the loaded frame |
| spi_done | input | 1 | Shift engine finished the current frame |
| spi_rx | input | 16 | Low 16 bits of the bits shifted in |

## Verification
The bench injects a done pulse during the idle, load and start cycles. A sequencer that reacted to these pulses would skip a phase or return early, and the comparison would show a missing load or an early ready. It changes the request fields right after acceptance, so a design that reads the live inputs instead of a captured copy would put the wrong index or value in a frame. It varies the done latency from one cycle upward and holds a request valid across completion, which exposes off-by-one timing in the second load and in the return of ready. Reads check both the long-frame length and the header-only payload, and that no response pulse appears for writes.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;
  localparam int HDR_W = 8;
  localparam int ID_W  = 6;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOAD  = 2'd1,
    ST_START = 2'd2,
    ST_WAIT  = 2'd3
  } seq_state_e;

  typedef enum logic {
    PH_INDEX = 1'b0,
    PH_DATA  = 1'b1
  } seq_phase_e;

  function automatic logic [HDR_W-1:0] mk_header(input logic [ID_W-1:0] id,
                                                 input logic sel, input logic dir);
    return {id, sel, dir};
  endfunction
endpackage

// File: rtl/seq_frame_build.sv
module seq_frame_build
  import lcd_seq_pkg::*;
#(
  parameter logic [ID_W-1:0] DEV_ID = 6'h1C,
  parameter int REG_W     = 16,
  parameter int SHORT_LEN = 24,
  parameter int LONG_LEN  = 32,
  parameter int LEN_W     = $clog2(LONG_LEN)
) (
  input  seq_phase_e            phase,
  input  logic                  is_write,
  input  logic [REG_W-1:0]      idx,
  input  logic [REG_W-1:0]      val,
  output logic [LONG_LEN-1:0]   frame,
  output logic [LEN_W-1:0]      len
);
  localparam logic [HDR_W-1:0] HDR_INDEX = mk_header(DEV_ID, 1'b0, 1'b0);
  localparam logic [HDR_W-1:0] HDR_DATA  = mk_header(DEV_ID, 1'b1, 1'b0);
  localparam logic [LEN_W-1:0] SHORT_M1  = LEN_W'(SHORT_LEN - 1);
  localparam logic [LEN_W-1:0] LONG_M1   = LEN_W'(LONG_LEN - 1);

  always_comb begin
    frame = '0;
    len   = SHORT_M1;
    if (phase == PH_INDEX) begin
      frame[SHORT_LEN-1 -: HDR_W] = HDR_INDEX;
      frame[REG_W-1:0]            = idx;
    end else if (is_write) begin
      frame[SHORT_LEN-1 -: HDR_W] = HDR_DATA;
      frame[REG_W-1:0]            = val;
    end else begin
      frame[LONG_LEN-1 -: HDR_W]  = HDR_DATA;
      len                         = LONG_M1;
    end
  end
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import lcd_seq_pkg::*;
#(
  parameter int REG_W     = 16,
  parameter int SHORT_LEN = 24,
  parameter int LONG_LEN  = 32,
  parameter int LEN_W     = $clog2(LONG_LEN)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [REG_W-1:0]     req_index,
  input  logic [REG_W-1:0]     req_wdata,
  output logic                 req_ready,
  input  logic [LONG_LEN-1:0]  frame_i,
  input  logic [LEN_W-1:0]     len_i,
  output seq_phase_e           phase_q,
  output logic                 wr_q,
  output logic [REG_W-1:0]     idx_q,
  output logic [REG_W-1:0]     val_q,
  output logic                 spi_load,
  output logic [LONG_LEN-1:0]  spi_tx,
  output logic [LEN_W-1:0]     spi_len,
  output logic                 spi_start,
  input  logic                 spi_done,
  output logic                 last_done
);
  seq_state_e state_q;

  assign last_done = (state_q == ST_WAIT) && spi_done && (phase_q == PH_DATA);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      req_ready <= 1'b1;
      spi_load  <= 1'b0;
      spi_start <= 1'b0;
      spi_tx    <= '0;
      spi_len   <= '0;
      phase_q   <= PH_INDEX;
      wr_q      <= 1'b0;
      idx_q     <= '0;
      val_q     <= '0;
    end else begin
      spi_load  <= 1'b0;
      spi_start <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            wr_q      <= req_write;
            idx_q     <= req_index;
            val_q     <= req_wdata;
            phase_q   <= PH_INDEX;
            req_ready <= 1'b0;
            state_q   <= ST_LOAD;
          end
        end
        ST_LOAD: begin
          spi_load <= 1'b1;
          spi_tx   <= frame_i;
          spi_len  <= len_i;
          state_q  <= ST_START;
        end
        ST_START: begin
          spi_start <= 1'b1;
          state_q   <= ST_WAIT;
        end
        ST_WAIT: begin
          if (spi_done) begin
            if (phase_q == PH_INDEX) begin
              phase_q <= PH_DATA;
              state_q <= ST_LOAD;
            end else begin
              req_ready <= 1'b1;
              state_q   <= ST_IDLE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  p_load_then_start_r5: assert property (@(posedge clk) disable iff (rst)
    spi_load |=> spi_start);
  p_load_start_apart_r5: assert property (@(posedge clk) disable iff (rst)
    !(spi_load && spi_start));
  p_busy_not_ready_r6: assert property (@(posedge clk) disable iff (rst)
    (spi_load || spi_start) |-> !req_ready);
  p_accept_drops_ready_r6: assert property (@(posedge clk) disable iff (rst)
    (req_ready && req_valid) |=> !req_ready);
  p_len_legal_r4: assert property (@(posedge clk) disable iff (rst)
    spi_load |-> (spi_len == LEN_W'(SHORT_LEN - 1) || spi_len == LEN_W'(LONG_LEN - 1)));
  p_short_pad_r2: assert property (@(posedge clk) disable iff (rst)
    (spi_load && spi_len == LEN_W'(SHORT_LEN - 1)) |-> (spi_tx[LONG_LEN-1:SHORT_LEN] == '0));
endmodule

// File: rtl/seq_rsp_capture.sv
module seq_rsp_capture #(
  parameter int REG_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              last_done,
  input  logic              is_write,
  input  logic              spi_done,
  input  logic [REG_W-1:0]  spi_rx,
  output logic              rsp_valid,
  output logic [REG_W-1:0]  rsp_rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= last_done && !is_write;
      if (last_done && !is_write) rsp_rdata <= spi_rx;
    end
  end

  p_rsp_after_done_r7: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(spi_done));
  p_rsp_single_r7: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);
endmodule

// File: rtl/lcd_reg_seq.sv
module lcd_reg_seq
  import lcd_seq_pkg::*;
#(
  parameter logic [5:0] DEV_ID = 6'h1C,
  parameter int REG_W     = 16,
  parameter int SHORT_LEN = 24,
  parameter int LONG_LEN  = 32,
  parameter int LEN_W     = $clog2(LONG_LEN)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [REG_W-1:0]     req_index,
  input  logic [REG_W-1:0]     req_wdata,
  output logic                 req_ready,
  output logic                 rsp_valid,
  output logic [REG_W-1:0]     rsp_rdata,
  output logic                 spi_load,
  output logic [LONG_LEN-1:0]  spi_tx,
  output logic [LEN_W-1:0]     spi_len,
  output logic                 spi_start,
  input  logic                 spi_done,
  input  logic [REG_W-1:0]     spi_rx
);
  seq_phase_e             phase_q;
  logic                   wr_q;
  logic [REG_W-1:0]       idx_q;
  logic [REG_W-1:0]       val_q;
  logic [LONG_LEN-1:0]    frame_w;
  logic [LEN_W-1:0]       len_w;
  logic                   last_done;

  seq_frame_build #(
    .DEV_ID(DEV_ID), .REG_W(REG_W), .SHORT_LEN(SHORT_LEN),
    .LONG_LEN(LONG_LEN), .LEN_W(LEN_W)
  ) u_build (
    .phase(phase_q), .is_write(wr_q), .idx(idx_q), .val(val_q),
    .frame(frame_w), .len(len_w)
  );

  seq_ctrl #(
    .REG_W(REG_W), .SHORT_LEN(SHORT_LEN), .LONG_LEN(LONG_LEN), .LEN_W(LEN_W)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_write(req_write),
    .req_index(req_index), .req_wdata(req_wdata), .req_ready(req_ready),
    .frame_i(frame_w), .len_i(len_w),
    .phase_q(phase_q), .wr_q(wr_q), .idx_q(idx_q), .val_q(val_q),
    .spi_load(spi_load), .spi_tx(spi_tx), .spi_len(spi_len),
    .spi_start(spi_start), .spi_done(spi_done), .last_done(last_done)
  );

  seq_rsp_capture #(.REG_W(REG_W)) u_cap (
    .clk(clk), .rst(rst), .last_done(last_done), .is_write(wr_q),
    .spi_done(spi_done), .spi_rx(spi_rx),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );
endmodule

// File: tb/sim_lcd_reg_seq.sv
`timescale 1ns/1ps
module sim_lcd_reg_seq;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_index = '0, req_wdata = '0;
  logic req_ready, rsp_valid, spi_load, spi_start;
  logic [15:0] rsp_rdata;
  logic [31:0] spi_tx;
  logic [4:0]  spi_len;
  logic spi_done = 1'b0;
  logic [15:0] spi_rx = '0;

  always #2 clk = ~clk;

  lcd_reg_seq u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_index(req_index), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .spi_load(spi_load),
    .spi_tx(spi_tx), .spi_len(spi_len), .spi_start(spi_start),
    .spi_done(spi_done), .spi_rx(spi_rx)
  );

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  // behavioural reference
  int m_step = 0, m_ph = 0, m_acc = 0;
  bit m_wr = 0;
  logic [15:0] m_idx = '0, m_val = '0;
  bit e_ready = 1, e_load = 0, e_start = 0, e_rv = 0;
  logic [31:0] e_tx = '0;
  logic [4:0]  e_len = '0;
  logic [15:0] e_rd = '0;

  // shift-engine emulation
  int lat = 1, cnt = 0, inject = 0, loads = 0;
  logic [15:0] rx_cfg = '0;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model_step();
    e_load = 0; e_start = 0; e_rv = 0; m_acc = 0;
    if (rst) begin
      m_step = 0; m_ph = 0; e_ready = 1; e_tx = '0; e_len = '0; e_rd = '0;
      return;
    end
    case (m_step)
      0: if (req_valid) begin
           m_wr = req_write; m_idx = req_index; m_val = req_wdata;
           m_ph = 0; e_ready = 0; m_step = 1; m_acc = 1;
         end
      1: begin
           e_load = 1;
           if (m_ph == 0)      begin e_tx = {8'h00, 8'h70, m_idx}; e_len = 5'd23; end
           else if (m_wr)      begin e_tx = {8'h00, 8'h72, m_val}; e_len = 5'd23; end
           else                begin e_tx = {8'h72, 24'h0};        e_len = 5'd31; end
           m_step = 2;
         end
      2: begin e_start = 1; m_step = 3; end
      default: if (spi_done) begin
           if (m_ph == 0) begin m_ph = 1; m_step = 1; end
           else begin
             m_step = 0; e_ready = 1;
             if (!m_wr) begin e_rv = 1; e_rd = spi_rx; end
           end
         end
    endcase
  endtask

  task automatic cycle();
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk("R6", "req_ready", 32'(req_ready), 32'(e_ready));
    chk("R5", "spi_load",  32'(spi_load),  32'(e_load));
    chk("R5", "spi_start", 32'(spi_start), 32'(e_start));
    chk(m_ph == 0 ? "R2" : (m_wr ? "R3" : "R4"), "spi_tx",  spi_tx, e_tx);
    chk(m_ph == 0 ? "R2" : (m_wr ? "R3" : "R4"), "spi_len", 32'(spi_len), 32'(e_len));
    chk("R7", "rsp_valid", 32'(rsp_valid), 32'(e_rv));
    chk("R7", "rsp_rdata", 32'(rsp_rdata), 32'(e_rd));
    if (spi_load) loads++;
    spi_done = 1'b0;
    if (inject != 0) begin spi_done = 1'b1; inject = 0; end
    if (spi_start) cnt = lat;
    else if (cnt > 0) begin
      cnt--;
      if (cnt == 0) begin spi_done = 1'b1; spi_rx = rx_cfg; end
    end
  endtask

  task automatic issue(input bit wr, input logic [15:0] idx, input logic [15:0] val, input bit scramble);
    req_valid = 1; req_write = wr; req_index = idx; req_wdata = val;
    do cycle(); while (m_acc == 0);
    req_valid = 0;
    if (scramble) begin req_write = ~wr; req_index = ~idx; req_wdata = ~val; end
  endtask

  task automatic drain();
    while (m_step != 0) cycle();
    cycle();
  endtask

  initial begin
    repeat (3) cycle();
    rst = 0;
    // R1: reset state
    chk("R1", "ready after reset", 32'(req_ready), 32'd1);
    chk("R1", "load/start/rsp after reset", {29'd0, spi_load, spi_start, rsp_valid}, 32'd0);

    // R2/R3: write with one-cycle done latency
    lat = 1; loads = 0;
    issue(1, 16'h0100, 16'h3000, 0); drain();
    chk("R5", "two loads per write", loads, 2);

    // R3: longer latency write
    lat = 5;
    issue(1, 16'h030D, 16'h1010, 0); drain();

    // R4/R7: read
    lat = 3; rx_cfg = 16'hA5C3;
    issue(0, 16'h0000, 16'h0000, 0); drain();
    chk("R7", "read data", 32'(rsp_rdata), 32'h0000A5C3);

    // R8: stray done during idle, then during the start cycle of a read
    lat = 2; rx_cfg = 16'h1234; loads = 0;
    inject = 1; cycle();
    chk("R8", "ready kept in idle", 32'(req_ready), 32'd1);
    issue(0, 16'hFFFF, 16'h0000, 0);
    inject = 1;
    drain();
    chk("R8", "loads with stray done", loads, 2);
    chk("R8", "read data with stray done", 32'(rsp_rdata), 32'h00001234);

    // R9: request inputs change right after acceptance
    lat = 2;
    issue(1, 16'h0029, 16'h03BF, 1);
    cycle();
    chk("R9", "index frame after scramble", spi_tx, {8'h00, 8'h70, 16'h0029});
    chk("R10", "header from identifier", 32'(spi_tx[23:16]), 32'h70);
    drain();

    // R10: held request, back-to-back
    lat = 1; loads = 0;
    req_valid = 1; req_write = 1; req_index = 16'hFFFF; req_wdata = 16'hFFFF;
    do cycle(); while (m_acc == 0);
    do cycle(); while (m_acc == 0);
    req_valid = 0;
    drain();
    chk("R10", "loads for two held requests", loads, 4);

    repeat (4) cycle();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule